// File: doc/BRIEF.md
# Timestamp Command Packet Parser

This block sits behind a byte-wide serial receiver and turns the incoming byte stream into checked command packets. While idle it hunts for the start marker `0x82`. After the marker it collects a command byte, a length byte, that many data bytes and two check bytes. The check bytes are an inverted XOR taken separately over the even and odd positions of the command buffer. Packets that pass the check are routed by command code. A timestamp packet (command 3) updates a 64-bit seconds-since-1970 register and pulses a strobe. Every other command is presented on a packet output channel as command, length and data fields.

Malformed or corrupted packets are dropped. For each one the block raises a one-cycle error pulse and increments a saturating bad-packet counter. Each accepted packet increments a saturating good-packet counter.

Both data paths use valid/ready. The byte input takes a byte on any cycle in which `in_valid` and `in_ready` are both high. The packet output holds `pkt_valid` and its fields steady until `pkt_ready` is seen. While a packet waits on that output, `in_ready` is low, so back-pressure from the packet consumer stalls the byte source. The timestamp output is a plain strobe and never stalls. `MAX_LEN` must be at least 8.

Top module: `tstamp_pkt_parser`

## Requirements
- R1: While hunting, any byte other than `0x82` is consumed and has no effect: no error, no output strobe and no counter change.
- R2: The check byte sent first must equal the bitwise inverse of the XOR of command-buffer positions 0, 2, 4 and so on. Position 0 is the command byte, position 1 is the length byte, and data byte i is position i+2. The check byte sent second must equal the inverse of the XOR of positions 1, 3, 5 and so on. The start byte is excluded from both. A packet meeting both, in that order, increments `good_cnt`.
- R3: If either check byte mismatches, the packet is dropped, `err` pulses high for exactly one cycle after the second check byte, and `bad_cnt` increments. `err` never coincides with `ts_valid`.
- R4: A length byte greater than `MAX_LEN` (60) aborts the packet at once. `err` pulses in the cycle after that byte, `bad_cnt` increments, and the next byte is treated as a hunt for the start marker.
- R5: A good packet with command 3 and length 4 to 8 loads `ts_secs`. Data byte i goes to bits 8i+7..8i, so the first data byte is least significant, and bytes above the length read as zero. `ts_valid` pulses for one cycle. `ts_secs` changes at no other time.
- R6: A command-3 packet whose length is below 4 or above 8 is treated as bad, even if its check bytes match. It raises an `err` pulse and increments `bad_cnt`.
- R7: A good packet with any command other than 3 raises `pkt_valid` with `pkt_cmd`, `pkt_len` and `pkt_data`. Data byte i is at bits 8i+7..8i, and bytes at or beyond the length are zero. These outputs stay stable until `pkt_ready` is high, and `in_ready` is low for as long as `pkt_valid` is high.
- R8: `good_cnt` and `bad_cnt` count up by one per event and hold at their all-ones value.
- R9: After reset, `in_ready` is 1; `pkt_valid`, `ts_valid` and `err` are 0; and `ts_secs`, `good_cnt` and `bad_cnt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can take a byte |
| in_data | input | 8 | Input byte |
| pkt_valid | output | 1 | Decoded non-timestamp packet available |
| pkt_ready | input | 1 | Consumer takes the packet |
| pkt_cmd | output | 8 | Command code of held packet |
| pkt_len | output | 8 | Data length of held packet |
| pkt_data | output | MAX_LEN*8 | Data bytes, byte 0 in the low bits |
| ts_valid | output | 1 | One-cycle strobe: `ts_secs` was loaded |
| ts_secs | output | 64 | Seconds since 1970-01-01 00:00 |
| err | output | 1 | One-cycle pulse per dropped packet |
| good_cnt | output | CNT_W | Saturating good-packet counter |
| bad_cnt | output | CNT_W | Saturating bad-packet counter |

## Verification
The bench keeps `MAX_LEN` at its default of 60, so the abort threshold, the full 60-byte loopback packet and the timestamp length window are all tested at their real values. It sets `CNT_W` to 3, so both counters reach their all-ones value of 7 after a handful of packets. That brings saturation and hold-at-maximum within reach of a short run. The same shortened counters are used throughout the checksum, routing and back-pressure cases.

// File: rtl/tpp_pkg.sv
`timescale 1ns/1ps
package tpp_pkg;
  localparam logic [7:0] START_BYTE  = 8'h82;
  localparam logic [7:0] CMD_TSTAMP  = 8'd3;
  localparam logic [7:0] TS_LEN_MIN  = 8'd4;
  localparam logic [7:0] TS_LEN_MAX  = 8'd8;
  localparam int         TS_BYTES    = 8;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_CMD,
    ST_LEN,
    ST_DATA,
    ST_CK_FIRST,
    ST_CK_SECOND
  } pstate_e;
endpackage

// File: rtl/tpp_cksum.sv
`timescale 1ns/1ps
// Two-lane XOR accumulator: even buffer positions fold into lane 0,
// odd positions into lane 1. Outputs are the expected (inverted) check bytes.
module tpp_cksum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] exp_first,
  output logic [7:0] exp_second
);
  logic [7:0] even_acc_q;
  logic [7:0] odd_acc_q;
  logic       odd_lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_acc_q <= '0;
      odd_acc_q  <= '0;
      odd_lane_q <= 1'b0;
    end else if (clr) begin
      even_acc_q <= '0;
      odd_acc_q  <= '0;
      odd_lane_q <= 1'b0;
    end else if (en) begin
      if (odd_lane_q) odd_acc_q  <= odd_acc_q ^ din;
      else            even_acc_q <= even_acc_q ^ din;
      odd_lane_q <= ~odd_lane_q;
    end
  end

  assign exp_first  = ~even_acc_q;
  assign exp_second = ~odd_acc_q;
endmodule

// File: rtl/tpp_satcnt.sv
`timescale 1ns/1ps
module tpp_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     count <= '0;
    else if (inc && (count != '1))  count <= count + 1'b1;
  end
endmodule

// File: rtl/tstamp_pkt_parser.sv
`timescale 1ns/1ps
module tstamp_pkt_parser
  import tpp_pkg::*;
#(
  parameter int MAX_LEN = 60,
  parameter int CNT_W   = 16,
  localparam int DW     = MAX_LEN * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [7:0]       pkt_cmd,
  output logic [7:0]       pkt_len,
  output logic [DW-1:0]    pkt_data,
  output logic             ts_valid,
  output logic [63:0]      ts_secs,
  output logic             err,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] bad_cnt
);
  pstate_e    state_q;
  logic [7:0] cmd_q, len_q, idx_q;
  logic [7:0] buf_q [MAX_LEN];
  logic       first_ok_q;
  logic       pkt_valid_q, ts_valid_q, err_q;
  logic [63:0] ts_q, ts_next;

  logic       take, start_hit, ck_en, len_bad, last_data;
  logic       pkt_end, sum_ok, is_ts, fmt_ok, good_ev, bad_ev;
  logic [7:0] exp_first, exp_second;

  assign in_ready  = !pkt_valid_q;
  assign take      = in_valid && in_ready;
  assign start_hit = take && (state_q == ST_HUNT) && (in_data == START_BYTE);
  assign ck_en     = take && ((state_q == ST_CMD) || (state_q == ST_LEN) ||
                              (state_q == ST_DATA));
  assign len_bad   = in_data > 8'(MAX_LEN);
  assign last_data = (idx_q + 8'd1) == len_q;
  assign pkt_end   = take && (state_q == ST_CK_SECOND);
  assign sum_ok    = first_ok_q && (in_data == exp_second);
  assign is_ts     = (cmd_q == CMD_TSTAMP);
  assign fmt_ok    = !is_ts || ((len_q >= TS_LEN_MIN) && (len_q <= TS_LEN_MAX));
  assign good_ev   = pkt_end && sum_ok && fmt_ok;
  assign bad_ev    = (pkt_end && !(sum_ok && fmt_ok)) ||
                     (take && (state_q == ST_LEN) && len_bad);

  tpp_cksum u_cksum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_hit),
    .en         (ck_en),
    .din        (in_data),
    .exp_first  (exp_first),
    .exp_second (exp_second)
  );

  // Frame state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_HUNT;
      cmd_q      <= '0;
      len_q      <= '0;
      idx_q      <= '0;
      first_ok_q <= 1'b0;
    end else if (take) begin
      unique case (state_q)
        ST_HUNT: if (start_hit) state_q <= ST_CMD;
        ST_CMD: begin
          cmd_q   <= in_data;
          state_q <= ST_LEN;
        end
        ST_LEN: begin
          if (len_bad) begin
            state_q <= ST_HUNT;
          end else begin
            len_q   <= in_data;
            idx_q   <= '0;
            state_q <= (in_data == 8'd0) ? ST_CK_FIRST : ST_DATA;
          end
        end
        ST_DATA: begin
          idx_q <= idx_q + 8'd1;
          if (last_data) state_q <= ST_CK_FIRST;
        end
        ST_CK_FIRST: begin
          first_ok_q <= (in_data == exp_first);
          state_q    <= ST_CK_SECOND;
        end
        ST_CK_SECOND: state_q <= ST_HUNT;
        default:      state_q <= ST_HUNT;
      endcase
    end
  end

  // Data byte store, cleared at each start marker so unused bytes read zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= '0;
    end else if (start_hit) begin
      for (int i = 0; i < MAX_LEN; i++) buf_q[i] <= '0;
    end else if (take && (state_q == ST_DATA)) begin
      for (int i = 0; i < MAX_LEN; i++)
        if (idx_q == 8'(i)) buf_q[i] <= in_data;
    end
  end

  always_comb begin
    ts_next = '0;
    for (int i = 0; i < TS_BYTES; i++) ts_next[8*i +: 8] = buf_q[i];
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_valid_q <= 1'b0;
      ts_valid_q  <= 1'b0;
      err_q       <= 1'b0;
      ts_q        <= '0;
    end else begin
      err_q      <= bad_ev;
      ts_valid_q <= good_ev && is_ts;
      if (good_ev && is_ts) ts_q <= ts_next;
      if (good_ev && !is_ts)           pkt_valid_q <= 1'b1;
      else if (pkt_valid_q && pkt_ready) pkt_valid_q <= 1'b0;
    end
  end

  tpp_satcnt #(.W(CNT_W)) u_good_cnt (
    .clk(clk), .rst_n(rst_n), .inc(good_ev), .count(good_cnt));
  tpp_satcnt #(.W(CNT_W)) u_bad_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bad_ev), .count(bad_cnt));

  genvar g;
  generate
    for (g = 0; g < MAX_LEN; g++) begin : g_flat
      assign pkt_data[8*g +: 8] = buf_q[g];
    end
  endgenerate

  assign pkt_valid = pkt_valid_q;
  assign pkt_cmd   = cmd_q;
  assign pkt_len   = len_q;
  assign ts_valid  = ts_valid_q;
  assign ts_secs   = ts_q;
  assign err       = err_q;
endmodule

// File: rtl/tpp_checker.sv
`timescale 1ns/1ps
module tpp_checker #(
  parameter int MAX_LEN = 60,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             pkt_valid,
  input logic             pkt_ready,
  input logic [7:0]       pkt_cmd,
  input logic [7:0]       pkt_len,
  input logic             ts_valid,
  input logic [63:0]      ts_secs,
  input logic             err,
  input logic [CNT_W-1:0] good_cnt,
  input logic [CNT_W-1:0] bad_cnt
);
  assert_err_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_err_vs_ts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err, ts_valid}));

  assert_ts_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_secs != $past(ts_secs)) |-> ts_valid);

  assert_pkt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_cmd) && $stable(pkt_len)));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !in_ready);

  assert_good_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (good_cnt == '1) |=> (good_cnt == '1));

  assert_bad_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_cnt == '1) |=> (bad_cnt == '1));

  assert_good_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (good_cnt != $past(good_cnt)) |-> (good_cnt == CNT_W'($past(good_cnt) + 1'b1)));

  assert_bad_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_cnt != $past(bad_cnt)) |-> (bad_cnt == CNT_W'($past(bad_cnt) + 1'b1)));
endmodule

bind tstamp_pkt_parser tpp_checker #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) u_tpp_checker (.*);

// File: tb/test_tstamp_pkt_parser.sv
`timescale 1ns/1ps
module test_tstamp_pkt_parser;
  localparam int MAX_LEN = 60;
  localparam int CNT_W   = 3;
  localparam int DW      = MAX_LEN * 8;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic pkt_ready = 1'b0;
  logic in_ready, pkt_valid, ts_valid, err;
  logic [7:0] pkt_cmd, pkt_len;
  logic [DW-1:0] pkt_data;
  logic [63:0] ts_secs;
  logic [CNT_W-1:0] good_cnt, bad_cnt;

  always #2.5 clk = ~clk;

  tstamp_pkt_parser #(.MAX_LEN(MAX_LEN), .CNT_W(CNT_W)) i_tstamp_pkt_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_cmd(pkt_cmd), .pkt_len(pkt_len), .pkt_data(pkt_data),
    .ts_valid(ts_valid), .ts_secs(ts_secs), .err(err),
    .good_cnt(good_cnt), .bad_cnt(bad_cnt));

  int checks = 0;
  int failures = 0;
  int err_seen = 0;
  int ts_seen = 0;
  int exp_good = 0;
  int exp_bad = 0;
  logic [63:0] exp_ts = '0;
  logic [7:0] pbuf [64];
  bit done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (err) err_seen++;
    if (ts_valid) ts_seen++;
  end

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  len;
    logic [63:0] data;
    logic        bad_ck;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'd3, 8'd8, 64'h0000_0001_4A3B_2C1D, 1'b0},
    '{8'd3, 8'd4, 64'hFFEE_DDCC_4B00_1234, 1'b0},
    '{8'd3, 8'd5, 64'h0000_0055_6677_8899, 1'b1},
    '{8'd1, 8'd1, 64'h0000_0000_0000_0001, 1'b0},
    '{8'd2, 8'd5, 64'h0000_0000_9896_8001, 1'b0},
    '{8'd0, 8'd0, 64'h0000_0000_0000_0000, 1'b0},
    '{8'd3, 8'd2, 64'h0000_0000_0000_ABCD, 1'b0},
    '{8'd3, 8'd9, 64'h0102_0304_0506_0708, 1'b0},
    '{8'd0, 8'd3, 64'h0000_0000_00C0_FFEE, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // mode 0: correct check bytes, 1: first corrupted, 2: second corrupted, 3: swapped
  task automatic send_pkt(input logic [7:0] cmd, input logic [7:0] len, input int mode);
    logic [7:0] ev, od;
    ev = cmd;
    od = len;
    for (int i = 0; i < len; i++) begin
      if (i % 2 == 0) ev ^= pbuf[i];
      else            od ^= pbuf[i];
    end
    ev = ~ev;
    od = ~od;
    if (mode == 1) ev ^= 8'h01;
    if (mode == 2) od ^= 8'h80;
    put_byte(8'h82);
    put_byte(cmd);
    put_byte(len);
    for (int i = 0; i < len; i++) put_byte(pbuf[i]);
    if (mode == 3) begin put_byte(od); put_byte(ev); end
    else           begin put_byte(ev); put_byte(od); end
    settle();
  endtask

  task automatic bump(input bit good);
    if (good) exp_good = (exp_good < int'(CMAX)) ? exp_good + 1 : exp_good;
    else      exp_bad  = (exp_bad  < int'(CMAX)) ? exp_bad + 1  : exp_bad;
  endtask

  task automatic drain();
    @(negedge clk);
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
    end
  end

  initial begin
    int e0, t0;
    logic [63:0] ts_exp;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(in_ready === 1'b1 && pkt_valid === 1'b0 && ts_valid === 1'b0 && err === 1'b0,
          "R9 reset outputs", {in_ready, pkt_valid, ts_valid, err}, 64'h8);
    check(ts_secs === 64'd0 && good_cnt === '0 && bad_cnt === '0,
          "R9 reset values", ts_secs, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle junk bytes have no effect
    e0 = err_seen; t0 = ts_seen;
    put_byte(8'h00); put_byte(8'hFF); put_byte(8'h7E); put_byte(8'h03); put_byte(8'h81);
    settle();
    check(err_seen == e0 && ts_seen == t0 && !pkt_valid, "R1 junk ignored",
          err_seen - e0, 0);
    check(good_cnt == '0 && bad_cnt == '0, "R1 counters untouched", {good_cnt, bad_cnt}, 0);

    // Table walk (R2, R3, R5, R6, R7)
    foreach (VECS[v]) begin
      bit bad, tsk;
      bad = VECS[v].bad_ck ||
            (VECS[v].cmd == 8'd3 && (VECS[v].len < 8'd4 || VECS[v].len > 8'd8));
      tsk = (VECS[v].cmd == 8'd3);
      for (int i = 0; i < 64; i++) pbuf[i] = (i < 8) ? VECS[v].data[8*i +: 8] : 8'(i);
      e0 = err_seen; t0 = ts_seen;
      send_pkt(VECS[v].cmd, VECS[v].len, VECS[v].bad_ck ? 1 : 0);
      bump(!bad);
      if (bad) begin
        check(err_seen == e0 + 1 && ts_seen == t0 && !pkt_valid,
              $sformatf("R3/R6 vec%0d dropped with err", v), err_seen - e0, 1);
        check(ts_secs == exp_ts, $sformatf("R5 vec%0d ts unchanged", v), ts_secs, exp_ts);
      end else if (tsk) begin
        ts_exp = '0;
        for (int i = 0; i < 8; i++)
          if (i < VECS[v].len) ts_exp[8*i +: 8] = VECS[v].data[8*i +: 8];
        exp_ts = ts_exp;
        check(ts_seen == t0 + 1 && err_seen == e0, $sformatf("R5 vec%0d strobe", v),
              ts_seen - t0, 1);
        check(ts_secs == exp_ts, $sformatf("R5 vec%0d seconds", v), ts_secs, exp_ts);
      end else begin
        check(pkt_valid && pkt_cmd == VECS[v].cmd && pkt_len == VECS[v].len,
              $sformatf("R7 vec%0d fields", v), {pkt_valid, pkt_cmd, pkt_len},
              {1'b1, VECS[v].cmd, VECS[v].len});
        check(pkt_data[63:0] == (VECS[v].data & ((64'd1 << (8*VECS[v].len)) - 1)) &&
              pkt_data[DW-1:64] == '0,
              $sformatf("R7 vec%0d data", v), pkt_data[63:0], VECS[v].data);
        drain();
      end
      check(good_cnt == CNT_W'(exp_good) && bad_cnt == CNT_W'(exp_bad),
            $sformatf("R2/R8 vec%0d counters", v), {good_cnt, bad_cnt}, {exp_good, exp_bad});
    end

    // R7: full-length loopback with back-pressure
    for (int i = 0; i < 64; i++) pbuf[i] = 8'(i * 7 + 3);
    send_pkt(8'd0, 8'd60, 0);
    bump(1'b1);
    begin
      bit ok;
      ok = pkt_valid && pkt_len == 8'd60;
      for (int i = 0; i < MAX_LEN; i++) if (pkt_data[8*i +: 8] != pbuf[i]) ok = 1'b0;
      check(ok, "R7 60-byte loopback data", pkt_data[63:0], {pbuf[7], pbuf[6], pbuf[5],
            pbuf[4], pbuf[3], pbuf[2], pbuf[1], pbuf[0]});
    end
    repeat (3) @(negedge clk);
    check(pkt_valid && !in_ready && pkt_len == 8'd60, "R7 held without ready",
          {pkt_valid, in_ready}, 64'h2);
    drain();
    check(!pkt_valid && in_ready, "R7 released by ready", {pkt_valid, in_ready}, 64'h1);

    // R4: length above limit aborts; following packet parses from hunt
    e0 = err_seen;
    put_byte(8'h82); put_byte(8'd0); put_byte(8'd61);
    bump(1'b0);
    for (int i = 0; i < 8; i++) pbuf[i] = 8'(8'h10 + i);
    send_pkt(8'd3, 8'd6, 0);
    bump(1'b1);
    exp_ts = 64'h0000_1514_1312_1110;
    check(err_seen == e0 + 1, "R4 abort error pulse", err_seen - e0, 1);
    check(ts_secs == exp_ts, "R4 recovery packet decoded", ts_secs, exp_ts);

    // R2: swapped and second-byte-corrupted check bytes rejected
    e0 = err_seen;
    send_pkt(8'd3, 8'd4, 3);
    bump(1'b0);
    send_pkt(8'd3, 8'd4, 2);
    bump(1'b0);
    check(err_seen == e0 + 2 && ts_secs == exp_ts, "R2 order and second lane enforced",
          err_seen - e0, 2);

    // R8: saturation of both counters
    for (int k = 0; k < 9; k++) begin
      send_pkt(8'd1, 8'd1, 0); bump(1'b1); drain();
      put_byte(8'h82); put_byte(8'd2); put_byte(8'hFF); bump(1'b0); settle();
    end
    check(good_cnt == CMAX && exp_good == int'(CMAX), "R8 good saturates", good_cnt, CMAX);
    check(bad_cnt == CMAX && exp_bad == int'(CMAX), "R8 bad saturates", bad_cnt, CMAX);

    done = 1'b1;
    summary();
  end
endmodule